// File: doc/BRIEF.md
# Branch Condition and Timing Unit

This unit settles control transfers for an 8-bit processor core. A decoded branch command arrives with its kind, a condition selector or an unconditional flag, the zero and carry flags, and the operands it may need. The kinds are relative jump, absolute jump, jump through HL, call and return. The unit evaluates the condition and works out the new program counter. It charges the machine-clock cost for that kind and outcome. Where the transfer touches the stack, it steps through an internal decision cycle and then a push or a pop, talking to a separate stack unit through request/acknowledge pairs.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the unit is idle, so back-pressure lasts for the whole of a branch. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low, the fields may change freely, since nothing is sampled. Completion is a plain one-cycle `done` strobe that carries the cost and the resulting program counter. The stack side is a level request that the unit holds until the matching acknowledge is seen on a clock edge. The `cmd_pc` input is the program counter after the instruction's operand bytes.

Top module: `branch_resolve_unit`

## Requirements
- R1: A command is accepted on an edge with `cmd_valid` and `cmd_ready` high. `cmd_ready` is high exactly when `busy` is low. `busy` is high from the cycle after acceptance through the cycle in which `done` is high.
- R2: Condition selector `cmd_cc` encodes 0 = taken if Z clear, 1 = taken if Z set, 2 = taken if C clear, 3 = taken if C set.
- R3: Kind 0 (relative jump) costs 12 when taken and 8 when not. Its target is `cmd_pc` plus the sign-extended 8-bit `cmd_offset`, wrapping modulo 2^16.
- R4: Kind 1 (absolute jump) costs 16 when taken and 12 when not. Its target is `cmd_imm`.
- R5: Kind 2 (jump through HL) is always taken, whatever the condition and flags. It costs 4 and its target is `cmd_hl`.
- R6: With `cmd_always` high, the branch is taken regardless of `cmd_cc` and the flags.
- R7: `done` is high for exactly one cycle per accepted command, with `done_cost` and `done_pc`. `done_pc` is the target when taken and `cmd_pc` when not. For kinds without a stack step, `done` rises in the cycle right after acceptance.
- R8: `push_req` and `pop_req` are never high together. Each stays high until its acknowledge is seen on an edge, and the unit then goes to completion in the next cycle. `push_data` is the accepted `cmd_pc`.
- R9: Kind 4 (return) with `cmd_always` low spends one internal cycle, then completes with cost 8 if not taken. If taken, it pops and completes with cost 20 and `done_pc` = `pop_data`. With `cmd_always` high it pops at once, without the internal cycle, at cost 16.
- R10: Kind 3 (call) costs 12 and does no push when not taken. When taken, it spends one internal cycle, then pushes, and completes with cost 24 and `done_pc` = `cmd_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_kind | input | 3 | 0 relative, 1 absolute, 2 via HL, 3 call, 4 return |
| cmd_cc | input | 2 | Condition selector (R2) |
| cmd_always | input | 1 | Unconditional form |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| cmd_pc | input | AW | Program counter after operands |
| cmd_offset | input | OW | Signed relative displacement |
| cmd_imm | input | AW | 16-bit immediate target |
| cmd_hl | input | AW | HL register pair value |
| busy | output | 1 | Branch in progress |
| push_req | output | 1 | Push request to stack unit |
| push_data | output | AW | Return address to push |
| push_ack | input | 1 | Push accepted |
| pop_req | output | 1 | Pop request to stack unit |
| pop_ack | input | 1 | Pop completed, data valid |
| pop_data | input | AW | Popped return address |
| done | output | 1 | One-cycle completion strobe |
| done_cost | output | CW | Machine-clock cost of the branch |
| done_pc | output | AW | Resulting program counter |

## Verification
Some properties are checked on every cycle by assertions:
- the two stack requests are exclusive;
- a request is held until its acknowledge arrives;
- the completion strobe lasts a single cycle;
- an accepted command raises `busy`;
- an unconditional command always resolves as taken.

The cost tables, the wrapped relative targets, the decision-cycle placement for calls and returns, and the popped address reaching `done_pc` can only be shown by the bench scenarios. The bench's reference model runs these against a stack responder with varied acknowledge delays.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [2:0] {
    BK_REL  = 3'd0,
    BK_ABS  = 3'd1,
    BK_HL   = 3'd2,
    BK_CALL = 3'd3,
    BK_RET  = 3'd4
  } br_kind_e;

  typedef enum logic [1:0] {
    CC_NZ = 2'd0,
    CC_Z  = 2'd1,
    CC_NC = 2'd2,
    CC_C  = 2'd3
  } cc_e;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_step_e;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_DECIDE = 3'd1,
    SQ_PUSH   = 3'd2,
    SQ_POP    = 3'd3,
    SQ_FINISH = 3'd4
  } seq_st_e;

  localparam int unsigned COST_REL_T   = 12;
  localparam int unsigned COST_REL_N   = 8;
  localparam int unsigned COST_ABS_T   = 16;
  localparam int unsigned COST_ABS_N   = 12;
  localparam int unsigned COST_HL      = 4;
  localparam int unsigned COST_CALL_T  = 24;
  localparam int unsigned COST_CALL_N  = 12;
  localparam int unsigned COST_RET_CT  = 20;
  localparam int unsigned COST_RET_CN  = 8;
  localparam int unsigned COST_RET_U   = 16;
endpackage

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
(
  input  logic [1:0] cc,
  input  logic       always_in,
  input  logic       z,
  input  logic       c,
  output logic       taken
);
  always_comb begin
    if (always_in) begin
      taken = 1'b1;
    end else begin
      unique case (cc_e'(cc))
        CC_NZ:   taken = !z;
        CC_Z:    taken = z;
        CC_NC:   taken = !c;
        CC_C:    taken = c;
        default: taken = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/brx_plan.sv
module brx_plan
  import brx_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int CW = 5
) (
  input  logic [2:0]    kind,
  input  logic          cond_taken,
  input  logic          always_in,
  input  logic [AW-1:0] pc,
  input  logic [OW-1:0] offset,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] hl,
  output logic [CW-1:0] cost,
  output logic [AW-1:0] new_pc,
  output logic          decide,
  output stk_step_e     step
);
  localparam int EXTW = AW - OW;

  logic [AW-1:0] rel_target;
  assign rel_target = pc + {{EXTW{offset[OW-1]}}, offset};

  always_comb begin
    cost   = CW'(COST_HL);
    new_pc = pc;
    decide = 1'b0;
    step   = STK_NONE;
    unique case (br_kind_e'(kind))
      BK_REL: begin
        cost   = cond_taken ? CW'(COST_REL_T) : CW'(COST_REL_N);
        new_pc = cond_taken ? rel_target : pc;
      end
      BK_ABS: begin
        cost   = cond_taken ? CW'(COST_ABS_T) : CW'(COST_ABS_N);
        new_pc = cond_taken ? imm : pc;
      end
      BK_HL: begin
        cost   = CW'(COST_HL);
        new_pc = hl;
      end
      BK_CALL: begin
        cost   = cond_taken ? CW'(COST_CALL_T) : CW'(COST_CALL_N);
        new_pc = cond_taken ? imm : pc;
        decide = cond_taken;
        step   = cond_taken ? STK_PUSH : STK_NONE;
      end
      BK_RET: begin
        decide = !always_in;
        step   = cond_taken ? STK_POP : STK_NONE;
        if (always_in)       cost = CW'(COST_RET_U);
        else if (cond_taken) cost = CW'(COST_RET_CT);
        else                 cost = CW'(COST_RET_CN);
      end
      default: begin
        cost   = CW'(COST_HL);
        new_pc = pc;
      end
    endcase
  end
endmodule

// File: rtl/brx_seq.sv
module brx_seq
  import brx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] plan_cost,
  input  logic [AW-1:0] plan_pc,
  input  logic          plan_decide,
  input  stk_step_e     plan_step,
  input  logic [AW-1:0] link_pc,
  input  logic          push_ack,
  input  logic          pop_ack,
  input  logic [AW-1:0] pop_data,
  output logic          idle,
  output logic          push_req,
  output logic [AW-1:0] push_data,
  output logic          pop_req,
  output logic          done,
  output logic [CW-1:0] done_cost,
  output logic [AW-1:0] done_pc
);
  seq_st_e       st;
  stk_step_e     step_q;
  logic [CW-1:0] cost_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] link_q;

  function automatic seq_st_e after_decide(input stk_step_e s);
    unique case (s)
      STK_PUSH: after_decide = SQ_PUSH;
      STK_POP:  after_decide = SQ_POP;
      default:  after_decide = SQ_FINISH;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      step_q <= STK_NONE;
      cost_q <= '0;
      pc_q   <= '0;
      link_q <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          cost_q <= plan_cost;
          pc_q   <= plan_pc;
          link_q <= link_pc;
          step_q <= plan_step;
          st     <= plan_decide ? SQ_DECIDE : after_decide(plan_step);
        end
        SQ_DECIDE: st <= after_decide(step_q);
        SQ_PUSH:   if (push_ack) st <= SQ_FINISH;
        SQ_POP: if (pop_ack) begin
          pc_q <= pop_data;
          st   <= SQ_FINISH;
        end
        SQ_FINISH: st <= SQ_IDLE;
        default:   st <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (st == SQ_IDLE);
  assign push_req  = (st == SQ_PUSH);
  assign pop_req   = (st == SQ_POP);
  assign done      = (st == SQ_FINISH);
  assign push_data = link_q;
  assign done_cost = cost_q;
  assign done_pc   = pc_q;

  assert_req_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req && pop_req));
  assert_push_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_ack |=> push_req);
  assert_pop_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !pop_ack |=> pop_req);
  assert_push_to_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && push_ack |=> done);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brx_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_kind,
  input  logic [1:0]    cmd_cc,
  input  logic          cmd_always,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic [AW-1:0] cmd_pc,
  input  logic [OW-1:0] cmd_offset,
  input  logic [AW-1:0] cmd_imm,
  input  logic [AW-1:0] cmd_hl,
  output logic          busy,
  output logic          push_req,
  output logic [AW-1:0] push_data,
  input  logic          push_ack,
  output logic          pop_req,
  input  logic          pop_ack,
  input  logic [AW-1:0] pop_data,
  output logic          done,
  output logic [CW-1:0] done_cost,
  output logic [AW-1:0] done_pc
);
  logic          cond_taken;
  logic [CW-1:0] plan_cost;
  logic [AW-1:0] plan_pc;
  logic          plan_decide;
  stk_step_e     plan_step;
  logic          seq_idle;
  logic          accept;

  brx_cond u_cond (
    .cc        (cmd_cc),
    .always_in (cmd_always),
    .z         (flag_z),
    .c         (flag_c),
    .taken     (cond_taken)
  );

  brx_plan #(.AW(AW), .OW(OW), .CW(CW)) u_plan (
    .kind       (cmd_kind),
    .cond_taken (cond_taken),
    .always_in  (cmd_always),
    .pc         (cmd_pc),
    .offset     (cmd_offset),
    .imm        (cmd_imm),
    .hl         (cmd_hl),
    .cost       (plan_cost),
    .new_pc     (plan_pc),
    .decide     (plan_decide),
    .step       (plan_step)
  );

  assign accept    = cmd_valid && seq_idle;
  assign cmd_ready = seq_idle;
  assign busy      = !seq_idle;

  brx_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .plan_cost   (plan_cost),
    .plan_pc     (plan_pc),
    .plan_decide (plan_decide),
    .plan_step   (plan_step),
    .link_pc     (cmd_pc),
    .push_ack    (push_ack),
    .pop_ack     (pop_ack),
    .pop_data    (pop_data),
    .idle        (seq_idle),
    .push_req    (push_req),
    .push_data   (push_data),
    .pop_req     (pop_req),
    .done        (done),
    .done_cost   (done_cost),
    .done_pc     (done_pc)
  );

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);
  assert_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_always |-> cond_taken);
endmodule

// File: tb/test_branch_resolve_unit.sv
module test_branch_resolve_unit;
  import brx_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = 0;
  logic [1:0]  cmd_cc = 0;
  logic        cmd_always = 0;
  logic        flag_z = 0;
  logic        flag_c = 0;
  logic [15:0] cmd_pc = 0;
  logic [7:0]  cmd_offset = 0;
  logic [15:0] cmd_imm = 0;
  logic [15:0] cmd_hl = 0;
  logic        busy;
  logic        push_req;
  logic [15:0] push_data;
  logic        push_ack = 0;
  logic        pop_req;
  logic        pop_ack = 0;
  logic [15:0] pop_data = 0;
  logic        done;
  logic [4:0]  done_cost;
  logic [15:0] done_pc;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int wait_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_unit i_branch_resolve_unit (.*);

  // behavioural reference: queue of remaining steps
  localparam int S_INT = 1, S_PUSH = 2, S_POP = 3, S_DONE = 4;
  int    steps[$];
  int    m_cost;
  int    m_pc;
  int    m_link;
  string m_tag;

  function automatic bit cond_ok(int cc, bit alw, bit z, bit c);
    if (alw) return 1;
    case (cc)
      0: return !z;
      1: return z;
      2: return !c;
      default: return c;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps.delete();
    end else if (steps.size() == 0) begin
      if (cmd_valid) begin
        bit t;
        int off;
        t = cond_ok(cmd_cc, cmd_always, flag_z, flag_c);
        m_link = cmd_pc;
        m_pc = cmd_pc;
        case (cmd_kind)
          0: begin
            m_tag = "R3";
            off = (cmd_offset >= 128) ? int'(cmd_offset) - 256 : int'(cmd_offset);
            m_cost = t ? 12 : 8;
            if (t) m_pc = (int'(cmd_pc) + off + 65536) % 65536;
            steps.push_back(S_DONE);
          end
          1: begin
            m_tag = "R4";
            m_cost = t ? 16 : 12;
            if (t) m_pc = cmd_imm;
            steps.push_back(S_DONE);
          end
          2: begin
            m_tag = "R5";
            m_cost = 4;
            m_pc = cmd_hl;
            steps.push_back(S_DONE);
          end
          3: begin
            m_tag = "R10";
            m_cost = t ? 24 : 12;
            if (t) begin
              m_pc = cmd_imm;
              steps.push_back(S_INT);
              steps.push_back(S_PUSH);
            end
            steps.push_back(S_DONE);
          end
          default: begin
            m_tag = "R9";
            if (cmd_always) begin
              m_cost = 16;
              steps.push_back(S_POP);
            end else begin
              steps.push_back(S_INT);
              m_cost = t ? 20 : 8;
              if (t) steps.push_back(S_POP);
            end
            steps.push_back(S_DONE);
          end
        endcase
      end
    end else begin
      case (steps[0])
        S_PUSH: if (push_ack) void'(steps.pop_front());
        S_POP: if (pop_ack) begin
          m_pc = pop_data;
          void'(steps.pop_front());
        end
        default: void'(steps.pop_front());
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int fr;
    fr = (steps.size() > 0) ? steps[0] : 0;
    check("R1", "busy", busy, steps.size() > 0);
    check("R1", "cmd_ready", cmd_ready, steps.size() == 0);
    check("R8", "push_req", push_req, fr == S_PUSH);
    check("R8", "pop_req", pop_req, fr == S_POP);
    check("R7", "done", done, fr == S_DONE);
    if (fr == S_PUSH) check("R8", "push_data", push_data, m_link);
    if (fr == S_DONE && done) begin
      check(m_tag, "done_cost", done_cost, m_cost);
      check(m_tag, "done_pc", done_pc, m_pc);
    end
  end

  // stack responder with programmable acknowledge delay
  always @(negedge clk) begin
    if (push_req || pop_req) begin
      if (wait_cnt >= lat) begin
        push_ack = push_req;
        pop_ack  = pop_req;
      end else begin
        push_ack = 0;
        pop_ack  = 0;
        wait_cnt++;
      end
    end else begin
      push_ack = 0;
      pop_ack  = 0;
      wait_cnt = 0;
    end
  end

  task automatic issue(int kind, int cc, bit alw, bit z, bit c,
                       int pc, int off, int imm, int hl);
    @(negedge clk); #1;
    cmd_kind = 3'(kind); cmd_cc = 2'(cc); cmd_always = alw;
    flag_z = z; flag_c = c; cmd_pc = 16'(pc); cmd_offset = 8'(off);
    cmd_imm = 16'(imm); cmd_hl = 16'(hl);
    cmd_valid = 1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    cmd_valid = 0;
    while (busy) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: idle, ready, no request (R1, R7, R8)
    check("R1", "reset busy", busy, 0);
    check("R1", "reset ready", cmd_ready, 1);
    check("R7", "reset done", done, 0);
    #1 rst_n = 1;

    // R2: every selector against every flag pair, relative jump (R3)
    for (int cc = 0; cc < 4; cc++)
      for (int f = 0; f < 4; f++)
        issue(0, cc, 0, f[0], f[1], 16'h1000 + f, 5, 0, 0);
    // R3: negative offset and wrap past zero / past top
    issue(0, 0, 1, 1, 1, 16'h0010, 8'h80, 0, 0);
    issue(0, 3, 0, 0, 1, 16'hFFFF, 8'h01, 0, 0);
    issue(0, 1, 0, 1, 0, 16'h0001, 8'hFE, 0, 0);
    // R4: absolute taken / not taken
    issue(1, 2, 0, 0, 1, 16'h2000, 0, 16'h4321, 0);
    issue(1, 3, 0, 0, 1, 16'h2000, 0, 16'h4321, 0);
    // R5: via HL with a condition that would fail
    issue(2, 0, 0, 1, 0, 16'h3000, 0, 16'h1111, 16'hA5A5);
    // R6: always flag with failing flags on absolute jump
    issue(1, 1, 1, 0, 0, 16'h2000, 0, 16'h7777, 0);
    // R10: calls, with varying push delay (R8)
    lat = 3;
    issue(3, 1, 0, 1, 0, 16'h5002, 0, 16'h6000, 0);
    issue(3, 2, 0, 0, 1, 16'h5002, 0, 16'h6000, 0);
    lat = 0;
    issue(3, 0, 1, 1, 1, 16'h5100, 0, 16'h6100, 0);
    // R9: returns
    lat = 2; pop_data = 16'hBEEF;
    issue(4, 0, 0, 1, 0, 16'h7000, 0, 0, 0);
    issue(4, 3, 0, 0, 1, 16'h7000, 0, 0, 0);
    lat = 4; pop_data = 16'h1234;
    issue(4, 0, 1, 1, 1, 16'h7000, 0, 0, 0);
    lat = 0; pop_data = 16'h0042;
    issue(4, 2, 0, 0, 0, 16'h7000, 0, 0, 0);

    // R1: valid held high across back-to-back commands
    @(negedge clk); #1;
    cmd_kind = 3'd3; cmd_cc = 2'd0; cmd_always = 1; cmd_pc = 16'h0100;
    cmd_imm = 16'h0200; lat = 1; cmd_valid = 1;
    repeat (14) @(negedge clk);
    #1 cmd_valid = 0;
    while (busy) begin @(negedge clk); #1; end
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule